// File: doc/BRIEF.md
# Segment Protection Fault Classifier

This unit decides, for one pending access, whether it may proceed or which protection fault vector it must raise. The caller describes the access: the segment register it goes through, what kind of access it is, the current, requested and descriptor privilege levels, and the flags computed elsewhere (descriptor present, access-rights violation, limit violation, I/O privilege level, virtual-8086 mode, and the I/O bitmap permit bit). Descriptor table walking, limit arithmetic and the delivery of the fault are left to neighbouring logic.

The classifier reports one of three vectors: 11 (segment not present), 12 (stack segment fault) or 13 (general protection). Which one it picks depends on the access kind and on whether the stack segment is involved. A selector-test access never faults. It signals a failed test by asserting a zero-flag-clear output instead. The result is registered: it appears one cycle after a request is presented and is held until the next request.

Top module: `seg_prot_top`

## Requirements
- R1: A memory operand access (kind code 0) through any segment other than the stack segment raises vector 13 when its limit flag or its access-rights flag is set. The segment codes are ES=0, CS=1, SS=2, DS=3, FS=4 and GS=5.
- R2: A memory operand access through the stack segment (code 2) that has its limit flag set raises vector 12. Such an access with only the access-rights flag set raises vector 13.
- R3: A segment load (kind code 1) whose descriptor is not present raises vector 11, or vector 12 when the target is the stack segment.
- R4: A present segment load fails privilege and raises vector 13 in these cases. For SS, the failure is any inequality among CPL, RPL and DPL. For CS, it is DPL differing from CPL. For other segments, it is max(CPL, RPL) greater than DPL. A present load that passes privilege raises vector 13 on a limit or access-rights flag.
- R5: A control transfer (kind code 2) raises vector 11 when the target is not present. It raises vector 13 when DPL differs from CPL, when RPL exceeds CPL, or when the limit or access-rights flag is set.
- R6: An I/O access (kind code 3) raises vector 13 when CPL is greater than IOPL outside virtual-8086 mode. In virtual-8086 mode it raises vector 13 when the permit bit is low, whatever the IOPL.
- R7: A privileged instruction (kind code 5) raises vector 13 when CPL is nonzero and no fault when CPL is 0.
- R8: A selector test (kind code 4) never raises a fault. It asserts zf_clear when the descriptor is not present or when max(CPL, RPL) is greater than DPL.
- R9: When several conditions hold, not-present takes precedence, then privilege, then limit, then access rights.
- R10: Results appear one clock after a cycle with req_valid high. They hold while req_valid is low, and a synchronous active-high reset clears all outputs.
- R11: fault_vec is zero whenever fault_valid is low, and unused kind codes 6 and 7 produce no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Capture the classification of this cycle's access |
| seg_sel | input | 3 | Segment register code (ES=0, CS=1, SS=2, DS=3, FS=4, GS=5) |
| acc_kind | input | 3 | Access kind (0 memory, 1 load, 2 transfer, 3 I/O, 4 selector test, 5 privileged) |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requested privilege level |
| dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present bit |
| rights_viol | input | 1 | Access-rights violation flag |
| limit_viol | input | 1 | Limit violation flag |
| iopl | input | 2 | I/O privilege level |
| v86_mode | input | 1 | Virtual-8086 mode |
| io_permit | input | 1 | I/O bitmap permits the port |
| fault_valid | output | 1 | Access must fault |
| fault_vec | output | 8 | Fault vector, zero when no fault |
| zf_clear | output | 1 | Selector test failed, clear the zero flag |

## Verification
If a condition is decoded under the wrong access kind or the wrong priority, the vector shows up wrong one clock after the request. The failure is most visible where 11, 12 and 13 split on the stack segment. If the capture register is enabled wrongly, it leaks a new result while req_valid is low, and the leak appears on the first idle cycle. A privilege fault that escapes the selector-test path shows as fault_valid together with zf_clear in the same cycle.

// File: rtl/seg_prot_pkg.sv
package seg_prot_pkg;

    typedef enum logic [2:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    typedef enum logic [2:0] {
        ACC_MEM   = 3'd0,
        ACC_LOAD  = 3'd1,
        ACC_XFER  = 3'd2,
        ACC_IO    = 3'd3,
        ACC_STEST = 3'd4,
        ACC_PRIV  = 3'd5
    } kind_e;

    localparam int PL_W  = 2;
    localparam int VEC_W = 8;

    localparam logic [VEC_W-1:0] VEC_NOT_PRESENT = VEC_W'(11);
    localparam logic [VEC_W-1:0] VEC_STACK       = VEC_W'(12);
    localparam logic [VEC_W-1:0] VEC_GENERAL     = VEC_W'(13);

    // Conditions raised by one access, before priority is applied
    typedef struct packed {
        logic np;        // target descriptor not present
        logic np_stack;  // not-present applies to the stack segment
        logic priv;      // privilege rule broken
        logic lim;       // limit exceeded
        logic lim_stack; // limit fault belongs to the stack segment
        logic rights;    // access rights broken
        logic zf;        // selector test failed
    } cond_t;

    typedef struct packed {
        logic             fault;
        logic [VEC_W-1:0] vec;
        logic             zf;
    } verdict_t;

    function automatic logic [PL_W-1:0] pl_max(input logic [PL_W-1:0] a,
                                               input logic [PL_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_prot_rules.sv
module seg_prot_rules
    import seg_prot_pkg::*;
(
    input  logic [2:0]      seg_sel,
    input  logic [2:0]      acc_kind,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] dpl,
    input  logic            desc_present,
    input  logic            rights_viol,
    input  logic            limit_viol,
    input  logic [PL_W-1:0] iopl,
    input  logic            v86_mode,
    input  logic            io_permit,
    output cond_t           cond
);
    seg_e  seg;
    kind_e kind;
    logic  is_stack;
    logic  eff_above_dpl;
    logic  load_priv_bad;

    assign seg           = seg_e'(seg_sel);
    assign kind          = kind_e'(acc_kind);
    assign is_stack      = (seg == SEG_SS);
    assign eff_above_dpl = pl_max(cpl, rpl) > dpl;

    always_comb begin
        case (seg)
            SEG_SS:  load_priv_bad = !((cpl == rpl) && (rpl == dpl));
            SEG_CS:  load_priv_bad = (dpl != cpl);
            default: load_priv_bad = eff_above_dpl;
        endcase
    end

    always_comb begin
        cond = '0;
        case (kind)
            ACC_MEM: begin
                cond.lim       = limit_viol;
                cond.lim_stack = is_stack;
                cond.rights    = rights_viol;
            end
            ACC_LOAD: begin
                cond.np       = !desc_present;
                cond.np_stack = is_stack;
                cond.priv     = load_priv_bad;
                cond.lim      = limit_viol;
                cond.rights   = rights_viol;
            end
            ACC_XFER: begin
                cond.np     = !desc_present;
                cond.priv   = (dpl != cpl) || (rpl > cpl);
                cond.lim    = limit_viol;
                cond.rights = rights_viol;
            end
            ACC_IO: begin
                cond.priv = v86_mode ? !io_permit : (cpl > iopl);
            end
            ACC_STEST: begin
                cond.zf = !desc_present || eff_above_dpl;
            end
            ACC_PRIV: begin
                cond.priv = (cpl != '0);
            end
            default: cond = '0;
        endcase
    end

endmodule

// File: rtl/seg_prot_arbiter.sv
module seg_prot_arbiter
    import seg_prot_pkg::*;
(
    input  cond_t    cond,
    output verdict_t verdict
);
    always_comb begin
        verdict       = '0;
        verdict.zf    = cond.zf;
        if (cond.np) begin
            verdict.fault = 1'b1;
            verdict.vec   = cond.np_stack ? VEC_STACK : VEC_NOT_PRESENT;
        end else if (cond.priv) begin
            verdict.fault = 1'b1;
            verdict.vec   = VEC_GENERAL;
        end else if (cond.lim) begin
            verdict.fault = 1'b1;
            verdict.vec   = cond.lim_stack ? VEC_STACK : VEC_GENERAL;
        end else if (cond.rights) begin
            verdict.fault = 1'b1;
            verdict.vec   = VEC_GENERAL;
        end
    end

endmodule

// File: rtl/seg_prot_top.sv
module seg_prot_top
    import seg_prot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       seg_sel,
    input  logic [2:0]       acc_kind,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  rpl,
    input  logic [PL_W-1:0]  dpl,
    input  logic             desc_present,
    input  logic             rights_viol,
    input  logic             limit_viol,
    input  logic [PL_W-1:0]  iopl,
    input  logic             v86_mode,
    input  logic             io_permit,
    output logic             fault_valid,
    output logic [VEC_W-1:0] fault_vec,
    output logic             zf_clear
);
    cond_t    cond;
    verdict_t verdict;
    verdict_t result_q;

    seg_prot_rules u_rules (
        .seg_sel      (seg_sel),
        .acc_kind     (acc_kind),
        .cpl          (cpl),
        .rpl          (rpl),
        .dpl          (dpl),
        .desc_present (desc_present),
        .rights_viol  (rights_viol),
        .limit_viol   (limit_viol),
        .iopl         (iopl),
        .v86_mode     (v86_mode),
        .io_permit    (io_permit),
        .cond         (cond)
    );

    seg_prot_arbiter u_arb (
        .cond    (cond),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (req_valid) begin
            result_q <= verdict;
        end
    end

    assign fault_valid = result_q.fault;
    assign fault_vec   = result_q.vec;
    assign zf_clear    = result_q.zf;

endmodule

// File: rtl/seg_prot_checker.sv
module seg_prot_checker
    import seg_prot_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [2:0]       seg_sel,
    input logic [2:0]       acc_kind,
    input logic [PL_W-1:0]  cpl,
    input logic             desc_present,
    input logic             fault_valid,
    input logic [VEC_W-1:0] fault_vec,
    input logic             zf_clear
);
    p_vec_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !fault_valid |-> (fault_vec == '0));

    p_vec_range_r9: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (fault_vec >= VEC_NOT_PRESENT && fault_vec <= VEC_GENERAL));

    p_zf_no_fault_r8: assert property (@(posedge clk) disable iff (rst)
        zf_clear |-> !fault_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(fault_valid) && $stable(fault_vec) && $stable(zf_clear)));

    p_stack_np_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_kind == 3'(ACC_LOAD) && seg_sel == 3'(SEG_SS) && !desc_present)
        |=> (fault_valid && fault_vec == VEC_STACK));

    p_priv_instr_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_kind == 3'(ACC_PRIV))
        |=> (fault_valid == ($past(cpl) != '0)));

    p_stest_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_kind == 3'(ACC_STEST)) |=> !fault_valid);

endmodule

bind seg_prot_top seg_prot_checker u_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .seg_sel      (seg_sel),
    .acc_kind     (acc_kind),
    .cpl          (cpl),
    .desc_present (desc_present),
    .fault_valid  (fault_valid),
    .fault_vec    (fault_vec),
    .zf_clear     (zf_clear)
);

// File: tb/tb_seg_prot_top.sv
module tb_seg_prot_top;

    typedef struct {
        logic       f;
        logic [7:0] v;
        logic       z;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] seg_sel = '0;
    logic [2:0] acc_kind = '0;
    logic [1:0] cpl = '0, rpl = '0, dpl = '0, iopl = '0;
    logic       desc_present = 1'b1, rights_viol = 1'b0, limit_viol = 1'b0;
    logic       v86_mode = 1'b0, io_permit = 1'b1;
    logic       fault_valid;
    logic [7:0] fault_vec;
    logic       zf_clear;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t sb[$];
    exp_t last_exp;
    bit   done = 0;

    always #5 clk = ~clk;

    seg_prot_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .seg_sel(seg_sel), .acc_kind(acc_kind),
        .cpl(cpl), .rpl(rpl), .dpl(dpl),
        .desc_present(desc_present), .rights_viol(rights_viol), .limit_viol(limit_viol),
        .iopl(iopl), .v86_mode(v86_mode), .io_permit(io_permit),
        .fault_valid(fault_valid), .fault_vec(fault_vec), .zf_clear(zf_clear)
    );

    // Reference outcome derived from the written requirements
    function automatic exp_t model(input logic [2:0] s, input logic [2:0] k,
                                   input logic [1:0] c, input logic [1:0] r,
                                   input logic [1:0] d, input logic p,
                                   input logic ar, input logic lim,
                                   input logic [1:0] io, input logic v8,
                                   input logic pm, input string tag);
        exp_t e;
        logic [1:0] eff;
        logic bad;
        e.f = 0; e.v = 0; e.z = 0; e.req = tag;
        eff = (c > r) ? c : r;
        if (k == 3'd0) begin
            if (lim)     begin e.f = 1; e.v = (s == 3'd2) ? 8'd12 : 8'd13; end
            else if (ar) begin e.f = 1; e.v = 8'd13; end
        end else if (k == 3'd1) begin
            if (s == 3'd2)      bad = !(c == r && r == d);
            else if (s == 3'd1) bad = (d != c);
            else                bad = (eff > d);
            if (!p)             begin e.f = 1; e.v = (s == 3'd2) ? 8'd12 : 8'd11; end
            else if (bad || lim || ar) begin e.f = 1; e.v = 8'd13; end
        end else if (k == 3'd2) begin
            if (!p) begin e.f = 1; e.v = 8'd11; end
            else if (d != c || r > c || lim || ar) begin e.f = 1; e.v = 8'd13; end
        end else if (k == 3'd3) begin
            if (v8 ? !pm : (c > io)) begin e.f = 1; e.v = 8'd13; end
        end else if (k == 3'd4) begin
            e.z = !p || (eff > d);
        end else if (k == 3'd5) begin
            if (c != 0) begin e.f = 1; e.v = 8'd13; end
        end
        return e;
    endfunction

    task automatic drive(input logic [2:0] s, input logic [2:0] k,
                         input logic [1:0] c, input logic [1:0] r, input logic [1:0] d,
                         input logic p, input logic ar, input logic lim,
                         input logic [1:0] io, input logic v8, input logic pm,
                         input string tag);
        @(negedge clk);
        req_valid = 1; seg_sel = s; acc_kind = k; cpl = c; rpl = r; dpl = d;
        desc_present = p; rights_viol = ar; limit_viol = lim;
        iopl = io; v86_mode = v8; io_permit = pm;
        last_exp = model(s, k, c, r, d, p, ar, lim, io, v8, pm, tag);
        sb.push_back(last_exp);
    endtask

    // Idle cycle with inputs that would fault: output must hold
    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 0; seg_sel = 3'd2; acc_kind = 3'd1; desc_present = 0;
        cpl = 2'd3;
        e = last_exp; e.req = tag;
        sb.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_tests++;
                if (fault_valid !== e.f || fault_vec !== e.v || zf_clear !== e.z) begin
                    n_fail++;
                    $display("FAIL %s: got f=%0b v=%0d z=%0b expected f=%0b v=%0d z=%0b",
                             e.req, fault_valid, fault_vec, zf_clear, e.f, e.v, e.z);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        last_exp = '{f: 0, v: 0, z: 0, req: "R10"};
        // R10 reset state
        rst = 1;
        repeat (3) @(posedge clk);
        #2;
        n_tests++;
        if (fault_valid !== 0 || fault_vec !== 0 || zf_clear !== 0) begin
            n_fail++;
            $display("FAIL R10 reset: got f=%0b v=%0d z=%0b expected 0 0 0",
                     fault_valid, fault_vec, zf_clear);
        end
        @(negedge clk); rst = 0;

        // args: seg kind cpl rpl dpl present ar lim iopl v86 permit
        drive(3'd3, 3'd0, 0, 0, 0, 1, 0, 1, 0, 0, 1, "R1 DS limit");
        drive(3'd5, 3'd0, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R1 GS rights");
        drive(3'd0, 3'd0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R11 clean mem");
        drive(3'd2, 3'd0, 0, 0, 0, 1, 0, 1, 0, 0, 1, "R2 SS limit");
        drive(3'd2, 3'd0, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R2 SS rights");
        drive(3'd2, 3'd0, 0, 0, 0, 1, 1, 1, 0, 0, 1, "R9 SS limit over rights");
        drive(3'd4, 3'd1, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R3 FS not present");
        drive(3'd2, 3'd1, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R3 SS not present");
        drive(3'd3, 3'd1, 1, 3, 2, 1, 0, 0, 0, 0, 1, "R4 DS rpl above dpl");
        drive(3'd3, 3'd1, 1, 1, 2, 1, 0, 0, 0, 0, 1, "R4 DS pass");
        drive(3'd2, 3'd1, 1, 1, 2, 1, 0, 0, 0, 0, 1, "R4 SS dpl mismatch");
        drive(3'd2, 3'd1, 2, 2, 2, 1, 0, 0, 0, 0, 1, "R4 SS pass");
        drive(3'd1, 3'd1, 0, 0, 3, 1, 0, 0, 0, 0, 1, "R4 CS dpl differs");
        drive(3'd3, 3'd1, 0, 0, 0, 1, 0, 1, 0, 0, 1, "R4 DS load limit");
        drive(3'd2, 3'd1, 3, 0, 0, 0, 1, 1, 0, 0, 1, "R9 SS np over priv");
        drive(3'd1, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R5 xfer not present");
        drive(3'd1, 3'd2, 1, 2, 1, 1, 0, 0, 0, 0, 1, "R5 xfer rpl above cpl");
        drive(3'd1, 3'd2, 2, 2, 2, 1, 0, 1, 0, 0, 1, "R5 xfer limit");
        drive(3'd1, 3'd2, 2, 2, 2, 1, 0, 0, 0, 0, 1, "R5 xfer pass");
        drive(3'd0, 3'd3, 3, 0, 0, 1, 0, 0, 1, 0, 1, "R6 io cpl above iopl");
        drive(3'd0, 3'd3, 1, 0, 0, 1, 0, 0, 1, 0, 0, "R6 io cpl equals iopl");
        drive(3'd0, 3'd3, 3, 0, 0, 1, 0, 0, 0, 1, 0, "R6 v86 denied");
        drive(3'd0, 3'd3, 3, 0, 0, 1, 0, 0, 0, 1, 1, "R6 v86 permitted");
        drive(3'd0, 3'd5, 1, 0, 0, 1, 0, 0, 0, 0, 1, "R7 cpl1");
        drive(3'd0, 3'd5, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R7 cpl0");
        drive(3'd3, 3'd4, 2, 3, 1, 1, 1, 1, 0, 0, 1, "R8 stest priv fail");
        drive(3'd3, 3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 stest not present");
        drive(3'd3, 3'd4, 1, 1, 2, 1, 0, 0, 0, 0, 1, "R8 stest pass");
        drive(3'd3, 3'd1, 3, 3, 0, 1, 0, 0, 0, 0, 1, "R10 fault before idle");
        idle("R10 hold after fault");
        idle("R10 hold second cycle");
        drive(3'd3, 3'd6, 3, 3, 0, 0, 1, 1, 0, 0, 0, "R11 kind 6");
        drive(3'd3, 3'd7, 3, 3, 0, 0, 1, 1, 0, 0, 0, "R11 kind 7");
        idle("R10 hold no fault");

        @(negedge clk); req_valid = 0;
        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule